// File: doc/BRIEF.md
# Burst-of-Two Separate-I/O Synchronous SRAM Model

This block is a synthesizable behavioural model of a synchronous static RAM with distinct write-data and read-data buses and a fixed burst of two words. Each command occupies one command slot of two clocks. The first clock of a slot is the command clock, and a command is sampled on the rising edge that ends it. The second clock is the second beat. A read returns the addressed word and its partner in the two clocks of the following slot. A write takes its two data beats, each with its own active-low byte-lane enables, in the two clocks of the following slot. The partner address is the command address with bit 0 inverted.

The read bus carries a drive flag that tells when the data lines would be actively driven. The flag timing depends on the previous command, so a read followed by a non-read keeps the bus driven for one extra beat. An echo clock output marks the command clocks and is always driven. Both data interfaces are plain streams with no back-pressure. Every command slot is accepted, and write beats must be presented in their slot. A host that cannot supply data issues a deselect or an aborted write.

Top module: `sio_b2_sram`

## Requirements
- R1: With `start_n` high in a command clock the slot is a deselect: `addr`, `rd_wrn`, `wr_data` and `lane_en_n` have no effect, and no word of the array changes.
- R2: With `start_n` low and `rd_wrn` high (read of address A), `rd_data` shows word A during the first clock of the next slot and word A with bit 0 inverted during the second clock.
- R3: With `start_n` low and `rd_wrn` low (write to address A), the beat on `wr_data` in the first clock of the next slot goes to word A, and the beat in the second clock goes to word A with bit 0 inverted.
- R4: `lane_en_n` bit i guards bits 8i+7..8i of `wr_data` and is sampled separately with each beat. A lane is stored only when its bit is 0 in that beat.
- R5: A write whose `lane_en_n` is all ones in both beats stores nothing.
- R6: In the first clock of slot N+1, `rd_drive` is 1 if command N or command N-1 was a read. In the second clock it is 1 only if command N was a read. When it is high only because N-1 was a read, `rd_data` still shows the second word of that read.
- R7: `echo_clk` is 1 in every command clock and 0 in every second-beat clock, so it toggles on every clock. It is never undriven.
- R8: While `rst_n` is low, `rd_drive` is 0 and `echo_clk` is 1. The first clock after release is a command clock.
- R9: A read issued directly after a write returns that write's data, including lanes of its second beat, even when both commands touch the same word pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every edge is one beat |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low command strobe, sampled in command clocks |
| rd_wrn | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address of the burst |
| wr_data | input | DW | Write beat data |
| lane_en_n | input | DW/8 | Active-low byte-lane enables for the current beat |
| rd_data | output | DW | Read beat data |
| rd_drive | output | 1 | High when the read bus is driven |
| echo_clk | output | 1 | High in command clocks, low in second-beat clocks |

## Verification
The bench builds the block with a 4-bit address and a 32-bit word. The small array means random traffic keeps landing on the same word pairs. A read therefore often follows a write to its own pair, which exercises the forwarding path. Four byte lanes allow mixed masks in which each beat stores a different subset of lanes. The random read, write and deselect mix produces every pairing of consecutive commands, so each case of the drive-flag rule appears many times.

// File: rtl/sio_b2_pkg.sv
package sio_b2_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } op_t;

  function automatic op_t decode_op(input logic start_n, input logic rd_wrn);
    op_t o;
    o.rd = !start_n && rd_wrn;
    o.wr = !start_n && !rd_wrn;
    return o;
  endfunction
endpackage

// File: rtl/sio_b2_seq.sv
module sio_b2_seq
  import sio_b2_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_n,
  input  logic          rd_wrn,
  input  logic [AW-1:0] addr,
  output logic          ph,
  output op_t           cur,
  output logic [AW-1:0] cur_addr,
  output logic          prv_rd
);
  // ph = 0 in command clocks, 1 in second-beat clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= 1'b0;
      cur      <= '0;
      cur_addr <= '0;
      prv_rd   <= 1'b0;
    end else begin
      ph <= ~ph;
      if (!ph) begin
        cur      <= decode_op(start_n, rd_wrn);
        cur_addr <= addr;
        prv_rd   <= cur.rd;
      end
    end
  end
endmodule

// File: rtl/sio_b2_wr.sv
module sio_b2_wr
  import sio_b2_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ph,
  input  op_t             cur,
  input  logic [AW-1:0]   cur_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW/8-1:0] lane_en_n,
  output logic            we,
  output logic [AW-1:0]   waddr,
  output logic [DW-1:0]   wdata,
  output logic [DW/8-1:0] wlane
);
  logic          beat2_pend;
  logic [AW-1:0] beat2_base;

  // A write sampled in slot N stores beat 0 at the command-clock edge of slot N+1
  // and beat 1 at the following edge, into the partner word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat2_pend <= 1'b0;
      beat2_base <= '0;
    end else if (!ph) begin
      beat2_pend <= cur.wr;
      beat2_base <= cur_addr;
    end
  end

  always_comb begin
    if (!ph) begin
      we    = cur.wr;
      waddr = cur_addr;
    end else begin
      we    = beat2_pend;
      waddr = {beat2_base[AW-1:1], ~beat2_base[0]};
    end
    wdata = wr_data;
    wlane = ~lane_en_n;
  end
endmodule

// File: rtl/sio_b2_array.sv
module sio_b2_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] wlane,
  input  logic [AW-1:0]   raddr,
  output logic [DW-1:0]   rdata
);
  localparam int NB    = DW / 8;
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < NB; i++) begin
        if (wlane[i]) mem[waddr][8*i +: 8] <= wdata[8*i +: 8];
      end
    end
  end

  // Lanes being stored in this clock are forwarded to a read of the same word.
  logic hit;
  assign hit = we && (waddr == raddr);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign rdata[8*g +: 8] = (hit && wlane[g]) ? wdata[8*g +: 8] : mem[raddr][8*g +: 8];
  end
endmodule

// File: rtl/sio_b2_out.sv
module sio_b2_out
  import sio_b2_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph,
  input  op_t           cur,
  input  logic          prv_rd,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_drive
);
  // Edge with ph=1 loads the first read beat; edge with ph=0 loads the second.
  // Without a read the last beat is held, which a trailing driven beat shows.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_drive <= 1'b0;
    end else begin
      if (cur.rd) rd_data <= rdata;
      if (ph) rd_drive <= cur.rd | prv_rd;
      else    rd_drive <= cur.rd;
    end
  end
endmodule

// File: rtl/sio_b2_sram.sv
module sio_b2_sram
  import sio_b2_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_n,
  input  logic            rd_wrn,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW/8-1:0] lane_en_n,
  output logic [DW-1:0]   rd_data,
  output logic            rd_drive,
  output logic            echo_clk
);
  localparam int NB = DW / 8;

  logic          ph;
  op_t           cur;
  logic [AW-1:0] cur_addr;
  logic          prv_rd;
  logic          we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;
  logic [NB-1:0] wlane;
  logic [AW-1:0] raddr;
  logic [DW-1:0] rdata;

  sio_b2_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .rd_wrn(rd_wrn), .addr(addr),
    .ph(ph), .cur(cur), .cur_addr(cur_addr), .prv_rd(prv_rd)
  );

  sio_b2_wr #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .ph(ph), .cur(cur), .cur_addr(cur_addr),
    .wr_data(wr_data), .lane_en_n(lane_en_n),
    .we(we), .waddr(waddr), .wdata(wdata), .wlane(wlane)
  );

  // First word read at the ph=1 edge, partner word at the ph=0 edge
  assign raddr = ph ? cur_addr : {cur_addr[AW-1:1], ~cur_addr[0]};

  sio_b2_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .wlane(wlane),
    .raddr(raddr), .rdata(rdata)
  );

  sio_b2_out #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .ph(ph), .cur(cur), .prv_rd(prv_rd),
    .rdata(rdata), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  assign echo_clk = ~ph;
endmodule

// File: rtl/sio_b2_chk.sv
module sio_b2_chk (
  input logic clk,
  input logic rst_n,
  input logic start_n,
  input logic rd_wrn,
  input logic rd_drive,
  input logic echo_clk
);
  logic [2:0] age;
  logic       rd_cmd;

  assign rd_cmd = !start_n && rd_wrn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R7
  echo_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1) |-> (echo_clk != $past(echo_clk)));

  // R6
  drive_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && echo_clk) |-> (rd_drive == ($past(rd_cmd, 2) || $past(rd_cmd, 4))));

  // R6
  drive_second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && !echo_clk) |-> (rd_drive == $past(rd_cmd, 3)));

  // R6
  drive_rise_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_drive) |-> echo_clk);

  // R8
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (!rd_drive && echo_clk);
    end
  end
endmodule

bind sio_b2_sram sio_b2_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_n(start_n), .rd_wrn(rd_wrn),
  .rd_drive(rd_drive), .echo_clk(echo_clk)
);

// File: tb/sim_sio_b2_sram.sv
module sim_sio_b2_sram;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_n = 1'b1;
  logic          rd_wrn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] lane_en_n = '1;
  logic [DW-1:0] rd_data;
  logic          rd_drive;
  logic          echo_clk;

  always #4 clk = ~clk;

  sio_b2_sram #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .rd_wrn(rd_wrn), .addr(addr),
    .wr_data(wr_data), .lane_en_n(lane_en_n),
    .rd_data(rd_data), .rd_drive(rd_drive), .echo_clk(echo_clk)
  );

  typedef struct {
    bit            drv;
    bit            echo;
    bit            chkq;
    logic [DW-1:0] q;
    string         tag;
  } exp_t;

  exp_t          sbq[$];
  logic [DW-1:0] ref_mem [WORDS];
  int            checks = 0;
  int            fails = 0;
  bit            mon_on = 0;
  bit            done = 0;

  // pending write of the previous command, and read history
  bit            pw = 0;
  logic [AW-1:0] pa;
  logic [DW-1:0] pd0, pd1;
  logic [NB-1:0] pm0, pm1;
  bit            prev_rd = 0;
  logic [DW-1:0] prev_q1 = '0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] mate(input logic [AW-1:0] a);
    return {a[AW-1:1], ~a[0]};
  endfunction

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] dv, input logic [NB-1:0] mn);
    for (int i = 0; i < NB; i++)
      if (!mn[i]) ref_mem[a][8*i +: 8] = dv[8*i +: 8];
  endtask

  // Scoreboard driver: called at a negedge inside a command clock.
  task automatic issue(input bit ld, input bit r, input logic [AW-1:0] a,
                       input logic [DW-1:0] d0, input logic [NB-1:0] m0,
                       input logic [DW-1:0] d1, input logic [NB-1:0] m1,
                       input string tag);
    bit rd;
    exp_t e0, e1;
    string t;
    rd = !ld && r;
    t = tag;
    if (pw) begin
      store(pa, pd0, pm0);
      store(mate(pa), pd1, pm1);
      if (rd && pa[AW-1:1] == a[AW-1:1]) t = "R9";
    end
    e0.drv = rd | prev_rd; e0.echo = 1'b1; e0.chkq = e0.drv;
    e0.q = rd ? ref_mem[a] : prev_q1; e0.tag = rd ? t : "R6";
    e1.drv = rd; e1.echo = 1'b0; e1.chkq = rd;
    e1.q = ref_mem[mate(a)]; e1.tag = t;
    sbq.push_back(e0);
    sbq.push_back(e1);
    start_n = ld; rd_wrn = r; addr = a;
    if (pw) begin wr_data = pd0; lane_en_n = pm0; end
    else begin wr_data = $urandom; lane_en_n = '0; end
    @(posedge clk); @(negedge clk);
    start_n = $urandom; rd_wrn = $urandom; addr = $urandom;
    if (pw) begin wr_data = pd1; lane_en_n = pm1; end
    else begin wr_data = $urandom; lane_en_n = '0; end
    @(posedge clk); @(negedge clk);
    pw = !ld && !r; pa = a; pd0 = d0; pd1 = d1; pm0 = m0; pm1 = m1;
    if (rd) prev_q1 = e1.q;
    prev_rd = rd;
  endtask

  task automatic rd_cmd(input logic [AW-1:0] a, input string tag);
    issue(1'b0, 1'b1, a, '0, '1, '0, '1, tag);
  endtask

  task automatic wr_cmd(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [NB-1:0] m0,
                        input logic [DW-1:0] d1, input logic [NB-1:0] m1);
    issue(1'b0, 1'b0, a, d0, m0, d1, m1, "R3");
  endtask

  task automatic idle(input string tag);
    issue(1'b1, $urandom, $urandom, $urandom, '0, $urandom, '0, tag);
  endtask

  // Scoreboard monitor
  initial begin
    wait (mon_on);
    while (!done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R6 queue-empty", '0, '0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(rd_drive == e.drv, "R6 rd_drive", DW'(rd_drive), DW'(e.drv));
        check(echo_clk == e.echo, "R7 echo_clk", DW'(echo_clk), DW'(e.echo));
        if (e.chkq) check(rd_data == e.q, e.tag, rd_data, e.q);
      end
      @(negedge clk);
    end
  end

  // Watchdog
  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", '0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(rd_drive == 1'b0, "R8 rd_drive", DW'(rd_drive), '0);
    check(echo_clk == 1'b1, "R8 echo_clk", DW'(echo_clk), DW'(1));
    rst_n = 1'b1;
    begin
      exp_t e;
      e.drv = 0; e.echo = 1; e.chkq = 0; e.q = '0; e.tag = "R8";
      sbq.push_back(e);
      e.echo = 0;
      sbq.push_back(e);
    end
    mon_on = 1;
    // fill every word (R3 two-beat placement)
    for (int i = 0; i < WORDS; i += 2)
      wr_cmd(AW'(i), $urandom, '0, $urandom, '0);
    // R3: beat 0 to A, beat 1 to A^1
    wr_cmd(4'd4, 32'hA0A0_A0A0, '0, 32'hB1B1_B1B1, '0);
    idle("R1");
    rd_cmd(4'd4, "R3");
    rd_cmd(4'd5, "R2");
    // R4: independent lane masks per beat, odd address
    wr_cmd(4'd5, 32'h1122_3344, 4'b1010, 32'h5566_7788, 4'b0101);
    idle("R1");
    rd_cmd(4'd4, "R4");
    // R5: all lanes disabled in both beats
    issue(1'b0, 1'b0, 4'd6, 32'hDEAD_BEEF, '1, 32'hFEED_FACE, '1, "R5");
    idle("R1");
    rd_cmd(4'd6, "R5");
    // R1: deselect with write-looking inputs and enabled lanes
    issue(1'b1, 1'b0, 4'd6, 32'h0BAD_0BAD, '0, 32'h0BAD_0BAD, '0, "R1");
    idle("R1");
    rd_cmd(4'd6, "R1");
    // R6: read then deselect, read then write, write then read
    rd_cmd(4'd2, "R2");
    idle("R6");
    rd_cmd(4'd3, "R2");
    wr_cmd(4'd8, 32'h0102_0304, 4'b0011, 32'h0506_0708, 4'b1100);
    // R9: read directly after a write to the same pair
    rd_cmd(4'd9, "R9");
    wr_cmd(4'd10, 32'hCAFE_0001, '0, 32'hCAFE_0002, 4'b0110);
    rd_cmd(4'd10, "R9");
    // random traffic
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [NB-1:0] m0, m1;
      op = $urandom % 3;
      m0 = $urandom; m1 = $urandom;
      if ($urandom % 8 == 0) begin m0 = '1; m1 = '1; end
      if (op == 0) idle("R1");
      else if (op == 1) rd_cmd($urandom, "R2");
      else issue(1'b0, 1'b0, $urandom, $urandom, m0, $urandom, m1, "R4");
    end
    for (int i = 0; i < WORDS; i += 2) rd_cmd(AW'(i), "R2");
    idle("R6");
    idle("R6");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule